// File: doc/BRIEF.md
# Snooping Invalidate Cache Controller

This block is the coherence controller of one cache in a small multiprocessor whose caches share one bus to memory. It keeps a direct-mapped array of one-word lines, each with a tag and a state. The state is Invalid (no data), Shared (a clean copy that can be read) or Exclusive (the only copy, writable and dirty). Writes are kept in the cache until the line is evicted. Before another cache may write a line, every other copy of that line is invalidated.

The processor side takes one request at a time. A read that hits, or a write that hits an Exclusive line, completes in the next cycle. Any other access raises a busy flag and requests the bus. The controller examines the line again only once the bus is granted. At that point it writes back a dirty victim if needed, then issues a read miss or a write miss. It installs the line when the bus acknowledges the miss.

The snoop side watches transactions from other caches. It supplies dirty data when it holds a line Exclusive. It downgrades the line on a foreign read miss and invalidates it on a foreign write miss.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: During and just after reset, every line is Invalid, and `cpu_busy`, `cpu_done`, `bus_req` and `snp_supply` are low, with `bus_cmd` at 0 (no command). The first access to any address is therefore a miss.
- R2: A read whose tag matches a Shared or Exclusive line, with no snoop in the same cycle, raises `cpu_done` in the next cycle. `cpu_rdata` then holds the line's data, `cpu_busy` stays low, and no bus command is issued.
- R3: A write to an Exclusive line with a matching tag, with no snoop in the same cycle, updates the data locally. It completes in the next cycle with no bus command, and the line stays Exclusive.
- R4: A read miss requests the bus and, after the grant, drives `bus_cmd` = 1 (read miss) with the request address. On `bus_ack`, the line is installed Shared with `bus_rdata`, and that value is returned on `cpu_rdata`.
- R5: A write to an Invalid line, a Shared line, or a line with another tag drives `bus_cmd` = 2 (write miss) after the grant. On `bus_ack`, the line is installed Exclusive with the processor's data.
- R6: While `bus_gnt` is low, `bus_cmd` stays 0. The line that a pending request targets is examined only in the cycle of the grant.
- R7: If the indexed line is Exclusive with another tag when the grant arrives, `bus_cmd` = 3 (write-back) is issued first, with the victim's address and data. The miss follows immediately after its `bus_ack`. A clean victim is dropped without a write-back.
- R8: A snooped read miss (`snp_cmd` = 1) that hits an Exclusive line raises `snp_supply` in the next cycle, with the line's data on `snp_data`. The line is downgraded to Shared.
- R9: A snooped write miss (`snp_cmd` = 2) that hits a line invalidates it, and supplies the data if the line was Exclusive. A snoop whose tag does not match changes nothing.
- R10: Once a miss is accepted, `cpu_busy` is high from the next cycle until the cycle in which the one-cycle `cpu_done` pulse appears. `cpu_done` and `cpu_busy` are never high together.
- R11: Once a command is on the bus, `bus_req`, `bus_cmd` and `bus_addr` are held until `bus_ack`.
- R12: If a snoop arrives in the same cycle as a processor request, the snoop acts on the array first. The request then goes through arbitration. If at the grant the line already satisfies it, the request completes without a bus command; otherwise it issues the miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle processor request, accepted while `cpu_busy` is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_busy | output | 1 | A coherence transaction is in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data (or written data) at completion |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership granted |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the bus command |
| bus_wdata | output | DATA_W | Data of a write-back |
| bus_ack | input | 1 | The current bus command is complete |
| bus_rdata | input | DATA_W | Line data returned with `bus_ack` |
| snp_valid | input | 1 | A foreign transaction is on the bus |
| snp_cmd | input | 2 | Foreign command, encoded as `bus_cmd` |
| snp_addr | input | ADDR_W | Foreign address |
| snp_supply | output | 1 | This cache supplies the dirty line |
| snp_data | output | DATA_W | Supplied line data |

## Verification
The checker watches bus sequencing on every cycle. It checks that no command appears before the grant, and that a command and its address are held until acknowledged. It also checks that a write-back is always followed by a miss, that a miss acknowledgement leads to completion, and that a supply pulse only follows a snoop. The data values, and the line states left behind by hits, misses, evictions and snoops, are only visible through the bench's scenarios. Each scenario compares returned data and the exact sequence of bus commands with a behavioural model. Later accesses reveal the downgrades and invalidations, as do the same-cycle collisions of a snoop with a processor request.

// File: rtl/snc_pkg.sv
package snc_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_st_t;

  localparam logic [1:0] BC_NONE   = 2'd0;
  localparam logic [1:0] BC_RDMISS = 2'd1;
  localparam logic [1:0] BC_WRMISS = 2'd2;
  localparam logic [1:0] BC_WBACK  = 2'd3;
endpackage

// File: rtl/snc_line_array.sv
module snc_line_array
  import snc_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  // processor-side port: read plus full-line write
  input  logic [IDX_W-1:0]  a_idx,
  output logic [TAG_W-1:0]  a_tag,
  output line_st_t          a_st,
  output logic [DATA_W-1:0] a_data,
  input  logic              a_we,
  input  logic [TAG_W-1:0]  a_wtag,
  input  line_st_t          a_wst,
  input  logic [DATA_W-1:0] a_wdata,
  // snoop-side port: read plus state-only write
  input  logic [IDX_W-1:0]  b_idx,
  output logic [TAG_W-1:0]  b_tag,
  output line_st_t          b_st,
  output logic [DATA_W-1:0] b_data,
  input  logic              b_we,
  input  line_st_t          b_wst
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  line_st_t          st_q  [LINES];

  // tag and data carry no reset so they can map onto RAM
  always_ff @(posedge clk) begin
    if (a_we) begin
      tag_q[a_idx] <= a_wtag;
      dat_q[a_idx] <= a_wdata;
    end
  end

  // the processor port wins; the bus protocol keeps both ports apart
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
    end else begin
      if (b_we) st_q[b_idx] <= b_wst;
      if (a_we) st_q[a_idx] <= a_wst;
    end
  end

  assign a_tag  = tag_q[a_idx];
  assign a_st   = st_q[a_idx];
  assign a_data = dat_q[a_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_st   = st_q[b_idx];
  assign b_data = dat_q[b_idx];
endmodule

// File: rtl/snc_snoop_unit.sv
module snc_snoop_unit
  import snc_pkg::*;
#(
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [TAG_W-1:0]  line_tag,
  input  line_st_t          line_st,
  input  logic [DATA_W-1:0] line_data,
  output logic              st_we,
  output line_st_t          st_new,
  output logic              supply,
  output logic [DATA_W-1:0] supply_data
);
  logic hit, is_rd, is_wr, dirty;

  always_comb begin
    is_rd  = snp_cmd == BC_RDMISS;
    is_wr  = snp_cmd == BC_WRMISS;
    hit    = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);
    dirty  = hit && (line_st == LS_EXC);
    st_we  = (hit && is_wr) || (dirty && is_rd);
    st_new = is_wr ? LS_INV : LS_SHR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      supply      <= 1'b0;
      supply_data <= '0;
    end else begin
      supply      <= dirty && (is_rd || is_wr);
      supply_data <= line_data;
    end
  end
endmodule

// File: rtl/snc_miss_fsm.sv
module snc_miss_fsm
  import snc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_busy,
  output logic                    cpu_done,
  output logic [DATA_W-1:0]       cpu_rdata,
  input  logic                    snp_valid,
  output logic [IDX_W-1:0]        line_idx,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  input  line_st_t                line_st,
  input  logic [DATA_W-1:0]       line_data,
  output logic                    arr_we,
  output logic [ADDR_W-IDX_W-1:0] arr_wtag,
  output line_st_t                arr_wst,
  output logic [DATA_W-1:0]       arr_wdata,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic [1:0]              bus_cmd,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_ack,
  input  logic [DATA_W-1:0]       bus_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {F_IDLE, F_GNT, F_WB, F_MISS} fsm_t;
  fsm_t fs;

  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_wdata;
  logic              rq_we;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic              sel_we, own_hit, local_ok;
  logic [1:0]        miss_cmd;

  always_comb begin
    sel_addr  = (fs == F_IDLE) ? cpu_addr  : rq_addr;
    sel_we    = (fs == F_IDLE) ? cpu_we    : rq_we;
    sel_wdata = (fs == F_IDLE) ? cpu_wdata : rq_wdata;
    line_idx  = sel_addr[IDX_W-1:0];
    own_hit   = (line_st != LS_INV) && (line_tag == sel_addr[ADDR_W-1:IDX_W]);
    local_ok  = own_hit && (!sel_we || line_st == LS_EXC);
    miss_cmd  = rq_we ? BC_WRMISS : BC_RDMISS;
  end

  always_comb begin
    arr_we    = 1'b0;
    arr_wtag  = line_tag;
    arr_wst   = line_st;
    arr_wdata = line_data;
    case (fs)
      F_IDLE: if (cpu_req && !snp_valid && local_ok && cpu_we) begin
        arr_we    = 1'b1;
        arr_wdata = cpu_wdata;
      end
      F_GNT: if (bus_gnt && local_ok && rq_we) begin
        arr_we    = 1'b1;
        arr_wdata = rq_wdata;
      end
      F_WB: if (bus_ack) begin
        arr_we  = 1'b1;
        arr_wst = LS_INV;
      end
      F_MISS: if (bus_ack) begin
        arr_we    = 1'b1;
        arr_wtag  = rq_addr[ADDR_W-1:IDX_W];
        arr_wst   = rq_we ? LS_EXC : LS_SHR;
        arr_wdata = rq_we ? rq_wdata : bus_rdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs        <= F_IDLE;
      cpu_busy  <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      bus_req   <= 1'b0;
      bus_cmd   <= BC_NONE;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rq_addr   <= '0;
      rq_wdata  <= '0;
      rq_we     <= 1'b0;
    end else begin
      cpu_done <= 1'b0;
      case (fs)
        F_IDLE: if (cpu_req) begin
          rq_addr  <= cpu_addr;
          rq_wdata <= cpu_wdata;
          rq_we    <= cpu_we;
          if (!snp_valid && local_ok) begin
            cpu_done  <= 1'b1;
            cpu_rdata <= cpu_we ? cpu_wdata : line_data;
          end else begin
            cpu_busy <= 1'b1;
            bus_req  <= 1'b1;
            fs       <= F_GNT;
          end
        end
        F_GNT: if (bus_gnt) begin
          if (local_ok) begin
            cpu_done  <= 1'b1;
            cpu_rdata <= sel_we ? sel_wdata : line_data;
            cpu_busy  <= 1'b0;
            bus_req   <= 1'b0;
            fs        <= F_IDLE;
          end else if (line_st == LS_EXC) begin
            bus_cmd   <= BC_WBACK;
            bus_addr  <= {line_tag, line_idx};
            bus_wdata <= line_data;
            fs        <= F_WB;
          end else begin
            bus_cmd   <= miss_cmd;
            bus_addr  <= rq_addr;
            bus_wdata <= rq_wdata;
            fs        <= F_MISS;
          end
        end
        F_WB: if (bus_ack) begin
          bus_cmd   <= miss_cmd;
          bus_addr  <= rq_addr;
          bus_wdata <= rq_wdata;
          fs        <= F_MISS;
        end
        F_MISS: if (bus_ack) begin
          bus_cmd   <= BC_NONE;
          bus_req   <= 1'b0;
          cpu_busy  <= 1'b0;
          cpu_done  <= 1'b1;
          cpu_rdata <= rq_we ? rq_wdata : bus_rdata;
          fs        <= F_IDLE;
        end
        default: fs <= F_IDLE;
      endcase
    end
  end

  logic [TAG_W-1:0] unused_tag_w;
  assign unused_tag_w = '0;
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import snc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag, a_wtag, b_tag;
  line_st_t          a_st, a_wst, b_st, b_wst;
  logic [DATA_W-1:0] a_data, a_wdata, b_data;
  logic              a_we, b_we;

  snc_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst(rst),
    .a_idx(a_idx), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
    .a_we(a_we), .a_wtag(a_wtag), .a_wst(a_wst), .a_wdata(a_wdata),
    .b_idx(snp_addr[IDX_W-1:0]), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
    .b_we(b_we), .b_wst(b_wst)
  );

  snc_miss_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .snp_valid(snp_valid),
    .line_idx(a_idx), .line_tag(a_tag), .line_st(a_st), .line_data(a_data),
    .arr_we(a_we), .arr_wtag(a_wtag), .arr_wst(a_wst), .arr_wdata(a_wdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  snc_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .line_tag(b_tag), .line_st(b_st), .line_data(b_data),
    .st_we(b_we), .st_new(b_wst),
    .supply(snp_supply), .supply_data(snp_data)
  );
endmodule

// File: rtl/snoop_coh_ctrl_chk.sv
module snoop_coh_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_busy,
  input logic              cpu_done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              snp_valid,
  input logic              snp_supply
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!bus_req && !cpu_busy && !cpu_done && !snp_supply && bus_cmd == 2'd0));

  // R6
  cmd_waits_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |-> (bus_cmd == 2'd0));

  // R11
  cmd_held_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != 2'd0 && !bus_ack) |=> ($stable(bus_cmd) && $stable(bus_addr)));

  // R11
  req_held_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_cmd != 2'd0 && !bus_ack) |=> bus_req);

  // R10
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !cpu_busy);

  // R10
  busy_with_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_busy) |-> $rose(bus_req));

  // R4
  miss_ack_done_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && (bus_cmd == 2'd1 || bus_cmd == 2'd2)) |=> (cpu_done && !bus_req));

  // R7
  wb_then_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && bus_cmd == 2'd3) |=> (bus_cmd == 2'd1 || bus_cmd == 2'd2));

  // R8
  supply_after_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> $past(snp_valid));
endmodule

bind snoop_coh_ctrl snoop_coh_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .bus_ack(bus_ack), .snp_valid(snp_valid), .snp_supply(snp_supply)
);

// File: tb/snoop_coh_ctrl_test.sv
module snoop_coh_ctrl_test;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LINES  = 1 << IDX_W;

  logic              clk, rst;
  logic              cpu_req, cpu_we;
  logic [ADDR_W-1:0] cpu_addr;
  logic [DATA_W-1:0] cpu_wdata;
  logic              cpu_busy, cpu_done;
  logic [DATA_W-1:0] cpu_rdata;
  logic              bus_req, bus_gnt, bus_ack;
  logic [1:0]        bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic              snp_valid;
  logic [1:0]        snp_cmd;
  logic [ADDR_W-1:0] snp_addr;
  logic              snp_supply;
  logic [DATA_W-1:0] snp_data;

  snoop_coh_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_supply(snp_supply), .snp_data(snp_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int gcnt = 0;
  int lat = 0;

  logic [DATA_W-1:0] mem [int];
  logic [1:0]        q_cmd [$];
  logic [ADDR_W-1:0] q_addr [$];
  logic [DATA_W-1:0] q_data [$];

  // reference model: 0 invalid, 1 shared, 2 exclusive
  int                m_st  [LINES];
  logic [TAG_W-1:0]  m_tag [LINES];
  logic [DATA_W-1:0] m_dat [LINES];

  function automatic logic [DATA_W-1:0] memval(input logic [ADDR_W-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 32'hC0DE_0000 | 32'(a);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] c, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    q_cmd.push_back(c);
    q_addr.push_back(a);
    q_data.push_back(d);
  endtask

  task automatic serve();
    string rq;
    rq = (bus_cmd == 2'd3) ? "R7" : ((bus_cmd == 2'd2) ? "R5" : "R4");
    if (q_cmd.size() == 0) begin
      chk(1'b0, rq, "unexpected bus command", 32'(bus_cmd), 32'd0);
    end else begin
      chk(bus_cmd == q_cmd[0] && bus_addr == q_addr[0], rq, "bus command and address",
          32'({bus_cmd, bus_addr}), 32'({q_cmd[0], q_addr[0]}));
      if (bus_cmd == 2'd3) chk(bus_wdata == q_data[0], "R7", "write-back data", bus_wdata, q_data[0]);
      void'(q_cmd.pop_front());
      void'(q_addr.pop_front());
      void'(q_data.pop_front());
    end
    if (bus_cmd == 2'd3) mem[int'(bus_addr)] = bus_wdata;
    else bus_rdata = memval(bus_addr);
  endtask

  // bus responder and watchdog, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(1'b0, "watchdog", "run did not finish", 32'(cyc), 32'd20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    bus_ack = 1'b0;
    if (rst) begin
      bus_gnt = 1'b0;
      gcnt = 0;
      lat = 0;
    end else begin
      // R6: a command may only be visible while the bus is granted
      if (bus_cmd != 2'd0) chk(bus_gnt, "R6", "command without grant", 32'(bus_gnt), 32'd1);
      if (bus_req && !bus_gnt) begin
        gcnt++;
        if (gcnt == 2) begin bus_gnt = 1'b1; gcnt = 0; end
      end else if (!bus_req && bus_gnt) begin
        bus_gnt = 1'b0;
        lat = 0;
      end else if (bus_gnt && bus_cmd != 2'd0) begin
        lat++;
        if (lat == 3) begin
          lat = 0;
          bus_ack = 1'b1;
          serve();
        end
      end
    end
  end

  task automatic m_snoop(input logic [1:0] c, input logic [ADDR_W-1:0] a,
                         output bit sup, output logic [DATA_W-1:0] d);
    int i;
    bit hit;
    i = int'(a[IDX_W-1:0]);
    hit = m_st[i] != 0 && m_tag[i] == a[ADDR_W-1:IDX_W];
    sup = hit && m_st[i] == 2 && (c == 2'd1 || c == 2'd2);
    d = m_dat[i];
    if (hit && c == 2'd2) m_st[i] = 0;
    else if (hit && c == 2'd1 && m_st[i] == 2) m_st[i] = 1;
    if (sup) mem[int'(a)] = d;
  endtask

  task automatic m_cpu(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                       output bit fast, output logic [DATA_W-1:0] rd);
    int i;
    bit hit;
    i = int'(a[IDX_W-1:0]);
    hit = m_st[i] != 0 && m_tag[i] == a[ADDR_W-1:IDX_W];
    if (hit && (!we || m_st[i] == 2)) begin
      fast = 1'b1;
      rd = we ? wd : m_dat[i];
      if (we) m_dat[i] = wd;
    end else begin
      fast = 1'b0;
      if (m_st[i] == 2) begin
        push(2'd3, {m_tag[i], a[IDX_W-1:0]}, m_dat[i]);
        mem[int'({m_tag[i], a[IDX_W-1:0]})] = m_dat[i];
      end
      if (we) begin
        push(2'd2, a, '0);
        rd = wd;
        m_st[i] = 2;
      end else begin
        push(2'd1, a, '0);
        rd = memval(a);
        m_st[i] = 1;
      end
      m_dat[i] = rd;
      m_tag[i] = a[ADDR_W-1:IDX_W];
    end
  endtask

  task automatic cpu_op(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        input string rq, input bit ws = 1'b0, input logic [1:0] sc = 2'd0,
                        input logic [ADDR_W-1:0] sa = '0);
    bit sup, fast;
    logic [DATA_W-1:0] sd, rd;
    int n;
    sup = 1'b0;
    sd = '0;
    if (ws) m_snoop(sc, sa, sup, sd);
    m_cpu(we, a, wd, fast, rd);
    if (ws) fast = 1'b0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    snp_valid = ws; snp_cmd = sc; snp_addr = sa;
    @(negedge clk);
    cpu_req = 1'b0;
    snp_valid = 1'b0;
    if (ws) begin
      // R12: the same-cycle snoop is answered as if it came first
      chk(snp_supply == sup, "R12", "collision snoop supply", 32'(snp_supply), 32'(sup));
      if (sup) chk(snp_data == sd, "R12", "collision snoop data", snp_data, sd);
    end
    if (fast) begin
      chk(cpu_done && !cpu_busy, rq, "hit completes next cycle", 32'({cpu_done, cpu_busy}), 32'b10);
    end else begin
      chk(cpu_busy && !cpu_done, "R10", "busy after accepted miss", 32'({cpu_busy, cpu_done}), 32'b10);
      n = 0;
      while (!cpu_done && n < 60) begin
        @(negedge clk);
        n++;
      end
      chk(cpu_done, "R10", "completion pulse", 32'(cpu_done), 32'd1);
    end
    chk(cpu_rdata == rd, rq, "returned data", cpu_rdata, rd);
    chk(q_cmd.size() == 0, rq, "expected bus commands all issued", 32'(q_cmd.size()), 32'd0);
    @(negedge clk);
    chk(!cpu_done, "R10", "done lasts one cycle", 32'(cpu_done), 32'd0);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [ADDR_W-1:0] a, input string rq);
    bit sup;
    logic [DATA_W-1:0] d;
    m_snoop(c, a, sup, d);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    chk(snp_supply == sup, rq, "snoop supply", 32'(snp_supply), 32'(sup));
    if (sup) chk(snp_data == d, rq, "snoop data", snp_data, d);
    @(negedge clk);
  endtask

  localparam logic [ADDR_W-1:0] A = 12'h010;
  localparam logic [ADDR_W-1:0] B = 12'h020;
  localparam logic [ADDR_W-1:0] C = 12'h013;
  localparam logic [ADDR_W-1:0] D = 12'h0A3;
  localparam logic [ADDR_W-1:0] E = 12'h015;

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0;
    end
    rst = 1'b1;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    bus_gnt = 1'b0; bus_ack = 1'b0; bus_rdata = '0;
    snp_valid = 1'b0; snp_cmd = 2'd0; snp_addr = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 quiet outputs after reset
    chk(!cpu_busy && !cpu_done && !bus_req && !snp_supply && bus_cmd == 2'd0, "R1",
        "outputs after reset", 32'({cpu_busy, cpu_done, bus_req, snp_supply, bus_cmd}), 32'd0);

    cpu_op(1'b0, A, '0, "R1");                 // cold read misses: R1, R4
    cpu_op(1'b0, A, '0, "R2");                 // read hit on Shared
    cpu_op(1'b1, A, 32'hAAAA_0001, "R5");      // write to Shared is a write miss
    cpu_op(1'b1, A, 32'hAAAA_0002, "R3");      // write hit on Exclusive
    cpu_op(1'b0, A, '0, "R2");                 // read hit on Exclusive
    cpu_op(1'b0, B, '0, "R7");                 // dirty victim written back first
    cpu_op(1'b0, A, '0, "R7");                 // clean victim dropped, no write-back
    cpu_op(1'b1, C, 32'h3333_0003, "R5");      // write to Invalid line
    snoop(2'd1, C, "R8");                      // supply and downgrade
    cpu_op(1'b1, C, 32'h4444_0004, "R8");      // downgraded line needs a write miss
    snoop(2'd2, C, "R9");                      // supply and invalidate
    cpu_op(1'b0, C, '0, "R9");                 // invalidated line misses, R4
    snoop(2'd2, A, "R9");                      // Shared copy invalidated, no supply
    cpu_op(1'b0, A, '0, "R9");
    snoop(2'd1, D, "R9");                      // tag mismatch, no change
    cpu_op(1'b0, C, '0, "R9");                 // C still hits
    cpu_op(1'b1, C, 32'h5555_0005, "R5");
    cpu_op(1'b0, C, '0, "R12", 1'b1, 2'd1, E); // collision, completes at grant with no command
    cpu_op(1'b1, C, 32'h6666_0006, "R12", 1'b1, 2'd1, C); // collision on same line
    cpu_op(1'b0, C, '0, "R12", 1'b1, 2'd2, C); // write-miss snoop removes line first
    cpu_op(1'b1, B, 32'h7777_0007, "R5");      // write miss over a Shared line of other tag
    cpu_op(1'b0, 12'h030, '0, "R7");           // evict dirty B

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule